// File: doc/BRIEF.md
# Configurable Register Logic Macrocell

This block is one output cell of a programmable-logic fabric. It receives a bank of product-term results that are OR-ed together, folds in a separate XOR term, and drives an output pin either directly from that logic value or from a single storage element. Static configuration inputs decide how the storage element behaves: as a D, T, J-K or S-R flip-flop, or as a level-sensitive latch. They also set the output polarity and the source and edge of the clock.

Each cell is clocked in one of two ways. In synchronous mode it takes one of several global clock lines and uses the chosen edge of it. In asynchronous mode it takes its clock, reset and preset from product terms, and that choice affects only this cell. All clock lines are sampled by the fabric's system clock. A cell update happens on the system clock edge where the sampled line shows the chosen transition. A test preload path forces the stored bit to any value, and the stored bit is always visible on an observability output.

Top module: `macrocell_core`

## Requirements
- R1: With `cfg_registered`=0 the pin is the logic value (OR of all `pt_sum` bits, XOR `xor_term`), XOR `cfg_invert`, in the same cycle with no clock involved.
- R2: With `cfg_registered`=1 the pin equals the stored bit when `cfg_invert`=0 and its complement when `cfg_invert`=1.
- R3: Kind code 0 (D): on a clock event the stored bit takes the logic value.
- R4: Kind code 1 (T): on a clock event the stored bit toggles when the logic value is 1 and holds when it is 0.
- R5: Kind code 2 (J-K, J = logic value, K = OR of `pt_aux`): on a clock event J=1/K=0 sets, J=0/K=1 clears, J=K=1 toggles, and J=K=0 holds.
- R6: Kind code 3 (S-R, S = logic value, R = OR of `pt_aux`): on a clock event S alone sets, R alone clears, and S=R=0 or S=R=1 holds.
- R7: Kind code 4 (latch): while the gate is active the stored bit follows the logic value on every system clock. While the gate is inactive it holds. The gate is the selected global line (active high when `cfg_clk_fall`=0) or, in asynchronous mode, `pt_clk`.
- R8: In synchronous mode the clock event is a rising transition (`cfg_clk_fall`=0) or a falling transition (`cfg_clk_fall`=1) of `gclk[cfg_clk_sel]`. The opposite transition and every other global line have no effect.
- R9: With `cfg_async`=1 the clock event is a rising transition of `pt_clk`, and the global lines are ignored. `pt_rst` clears the bit, `pt_rst` wins over `pt_set`, and both win over clocked data. With `cfg_async`=0, `pt_rst` and `pt_set` have no effect.
- R10: While `rst_n` is low at a system clock edge the stored bit becomes 0, so the pin shows `cfg_invert` in registered mode.
- R11: `preload_en`=1 loads `preload_val` at the next system clock edge. It overrides clocked updates and the product-term reset and preset, and `q_obs` always shows the stored bit.
- R12: Any single asserted bit of `pt_sum` makes the OR term 1, and `xor_term`=1 inverts the combined value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every line |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| pt_sum | input | NUM_PT | Product-term results OR-ed into the main logic value |
| pt_aux | input | NUM_PT | Product-term results OR-ed into the second input (K or R) |
| xor_term | input | 1 | Term XOR-ed with the OR of `pt_sum` |
| gclk | input | NUM_GCLK | Global clock lines |
| pt_clk | input | 1 | Product-term clock or gate for asynchronous mode |
| pt_rst | input | 1 | Product-term reset for asynchronous mode |
| pt_set | input | 1 | Product-term preset for asynchronous mode |
| cfg_registered | input | 1 | 1 selects the stored bit for the pin, 0 the logic value |
| cfg_invert | input | 1 | Output polarity, 1 inverts |
| cfg_kind | input | 3 | Storage kind: 0 D, 1 T, 2 J-K, 3 S-R, 4 latch |
| cfg_async | input | 1 | 1 selects asynchronous (product-term) control |
| cfg_clk_sel | input | $clog2(NUM_GCLK) | Index of the global clock line |
| cfg_clk_fall | input | 1 | 1 selects the falling transition |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 1 | Value written by preload |
| q_obs | output | 1 | Stored bit, for observation |
| pin_out | output | 1 | Cell output after polarity |

## Verification
The hardest state to reach is a cycle in which several update sources compete: a clock event, a product-term reset and preset, and a preload all active at once. The priority order is only visible when these requests disagree about the result. The stimulus first sets up a stored value that each lower-priority source would change. It then raises the competing controls together in one cycle and checks which one won. It also switches the clock source and edge while all lines are idle, then pulses the unselected lines and the opposite transition, to show that they leave the stored bit alone.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
// Package mc_pkg
// Shared types for the macrocell: storage kind codes and the bundle of
// product-term control signals used in asynchronous mode.
package mc_pkg;

    typedef enum logic [2:0] {
        ST_D     = 3'd0,
        ST_T     = 3'd1,
        ST_JK    = 3'd2,
        ST_SR    = 3'd3,
        ST_LATCH = 3'd4
    } store_kind_e;

    typedef struct packed {
        logic clk;
        logic rst;
        logic set;
    } pt_ctl_t;

endpackage

// File: rtl/mc_term_sum.sv
`timescale 1ns/1ps
// Module mc_term_sum
// Folds the product-term banks into the two logic inputs of the cell.
// The main input is the OR of pt_sum XOR xor_term. The second input (K or R)
// is the OR of pt_aux. This module is purely combinational.
module mc_term_sum #(
    parameter int NUM_PT = 20
) (
    input  logic [NUM_PT-1:0] pt_sum,
    input  logic [NUM_PT-1:0] pt_aux,
    input  logic              xor_term,
    output logic              data_a,
    output logic              data_b
);

    logic [NUM_PT:0] sum_chain;
    logic [NUM_PT:0] aux_chain;

    assign sum_chain[0] = 1'b0;
    assign aux_chain[0] = 1'b0;

    // OR chains over the product terms, one stage per term
    for (genvar g = 0; g < NUM_PT; g++) begin : g_or
        assign sum_chain[g+1] = sum_chain[g] | pt_sum[g];
        assign aux_chain[g+1] = aux_chain[g] | pt_aux[g];
    end

    // Apply the XOR term to the main sum
    always_comb begin
        data_a = sum_chain[NUM_PT] ^ xor_term;
        data_b = aux_chain[NUM_PT];
    end

endmodule

// File: rtl/mc_clock_sel.sv
`timescale 1ns/1ps
// Module mc_clock_sel
// Picks the clock source for the cell and turns transitions into one-cycle
// events in the system clock domain.
// Assumes: every line is synchronous to clk; configuration is static, or
// changes only while the selected line is idle.
module mc_clock_sel #(
    parameter int NUM_GCLK = 4,
    localparam int SEL_W   = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic [SEL_W-1:0]    clk_sel,
    input  logic                clk_fall,
    input  logic                async_mode,
    input  logic                pt_clk,
    output logic                fire,
    output logic                gate_open
);

    logic sel_level;
    logic eff_level;
    logic prev_eff;

    // Choose the source and fold in the edge choice (async uses pt_clk rising)
    always_comb begin
        sel_level = gclk[clk_sel];
        if (async_mode) begin
            eff_level = pt_clk;
        end else begin
            eff_level = sel_level ^ clk_fall;
        end
    end

    // Keep the previous level. It tracks through reset, so no false edge appears afterwards.
    always_ff @(posedge clk) begin
        prev_eff <= eff_level;
    end

    // An event is a low-to-high change of the effective level; events are masked during reset
    always_comb begin
        fire      = rst_n && eff_level && !prev_eff;
        gate_open = eff_level;
    end

    AST_SYNC_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!async_mode && !clk_fall && fire && $stable(clk_sel) && $stable(async_mode))
        |-> (gclk[clk_sel] && !$past(gclk[clk_sel])))
        else $error("event without rising global clock"); // R8

    AST_ASYNC_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (async_mode && fire && $stable(async_mode)) |-> (pt_clk && !$past(pt_clk)))
        else $error("event without rising product-term clock"); // R9

endmodule

// File: rtl/mc_store.sv
`timescale 1ns/1ps
// Module mc_store
// The cell's single storage bit, reconfigured as D, T, J-K, S-R or latch.
// Priority: reset, preload, product-term reset, product-term preset, then
// the kind-specific update. The product-term controls act only in async mode.
// Assumes: fire is a one-cycle event and gate_open is a level.
module mc_store
    import mc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  store_kind_e kind,
    input  logic        async_mode,
    input  logic        fire,
    input  logic        gate_open,
    input  logic        data_a,
    input  logic        data_b,
    input  pt_ctl_t     pt_ctl,
    input  logic        preload_en,
    input  logic        preload_val,
    output logic        state_q
);

    logic next_state;
    logic force_clr;
    logic force_set;

    // Decode the asynchronous-mode overrides
    always_comb begin
        force_clr = async_mode && pt_ctl.rst;
        force_set = async_mode && pt_ctl.set && !pt_ctl.rst;
    end

    // Kind-specific next state; anything that does not update holds
    always_comb begin
        next_state = state_q;
        case (kind)
            ST_D: begin
                if (fire) next_state = data_a;
            end
            ST_T: begin
                if (fire && data_a) next_state = ~state_q;
            end
            ST_JK: begin
                if (fire) begin
                    case ({data_a, data_b})
                        2'b10:   next_state = 1'b1;
                        2'b01:   next_state = 1'b0;
                        2'b11:   next_state = ~state_q;
                        default: next_state = state_q;
                    endcase
                end
            end
            ST_SR: begin
                if (fire) begin
                    case ({data_a, data_b})
                        2'b10:   next_state = 1'b1;
                        2'b01:   next_state = 1'b0;
                        default: next_state = state_q;
                    endcase
                end
            end
            ST_LATCH: begin
                if (gate_open) next_state = data_a;
            end
            default: next_state = state_q;
        endcase
    end

    // The storage bit with its fixed priority order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= 1'b0;
        end else if (preload_en) begin
            state_q <= preload_val;
        end else if (force_clr) begin
            state_q <= 1'b0;
        end else if (force_set) begin
            state_q <= 1'b1;
        end else begin
            state_q <= next_state;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> !state_q)
        else $error("reset did not clear"); // R10

    AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en |=> (state_q == $past(preload_val)))
        else $error("preload not taken"); // R11

    AST_PT_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (async_mode && pt_ctl.rst && !preload_en) |=> !state_q)
        else $error("product-term reset not taken"); // R9

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ST_T && fire && data_a && !preload_en
         && !(async_mode && (pt_ctl.rst || pt_ctl.set)))
        |=> (state_q != $past(state_q)))
        else $error("toggle did not flip"); // R4

endmodule

// File: rtl/macrocell_core.sv
`timescale 1ns/1ps
// Module macrocell_core
// A programmable-logic output cell: logic folding, clock selection, one
// reconfigurable storage bit, and the polarity stage for the pin.
// Assumes: configuration inputs are static in normal use; every input is
// synchronous to clk.
module macrocell_core
    import mc_pkg::*;
#(
    parameter int NUM_PT   = 20,
    parameter int NUM_GCLK = 4,
    localparam int SEL_W   = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PT-1:0]   pt_sum,
    input  logic [NUM_PT-1:0]   pt_aux,
    input  logic                xor_term,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                pt_clk,
    input  logic                pt_rst,
    input  logic                pt_set,
    input  logic                cfg_registered,
    input  logic                cfg_invert,
    input  logic [2:0]          cfg_kind,
    input  logic                cfg_async,
    input  logic [SEL_W-1:0]    cfg_clk_sel,
    input  logic                cfg_clk_fall,
    input  logic                preload_en,
    input  logic                preload_val,
    output logic                q_obs,
    output logic                pin_out
);

    logic        data_a;
    logic        data_b;
    logic        fire;
    logic        gate_open;
    logic        state_q;
    pt_ctl_t     pt_ctl;
    store_kind_e kind;

    // Bundle the product-term controls and decode the kind code
    always_comb begin
        pt_ctl.clk = pt_clk;
        pt_ctl.rst = pt_rst;
        pt_ctl.set = pt_set;
        kind       = store_kind_e'(cfg_kind);
    end

    mc_term_sum #(
        .NUM_PT   (NUM_PT)
    ) u_sum (
        .pt_sum   (pt_sum),
        .pt_aux   (pt_aux),
        .xor_term (xor_term),
        .data_a   (data_a),
        .data_b   (data_b)
    );

    mc_clock_sel #(
        .NUM_GCLK   (NUM_GCLK)
    ) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .gclk       (gclk),
        .clk_sel    (cfg_clk_sel),
        .clk_fall   (cfg_clk_fall),
        .async_mode (cfg_async),
        .pt_clk     (pt_ctl.clk),
        .fire       (fire),
        .gate_open  (gate_open)
    );

    mc_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .kind        (kind),
        .async_mode  (cfg_async),
        .fire        (fire),
        .gate_open   (gate_open),
        .data_a      (data_a),
        .data_b      (data_b),
        .pt_ctl      (pt_ctl),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .state_q     (state_q)
    );

    // Output selection and polarity
    always_comb begin
        q_obs   = state_q;
        pin_out = (cfg_registered ? state_q : data_a) ^ cfg_invert;
    end

endmodule

// File: tb/macrocell_core_test.sv
`timescale 1ns/1ps
module macrocell_core_test;

    localparam int NPT = 20;
    localparam int NGC = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NPT-1:0] pt_sum, pt_aux;
    logic           xor_term;
    logic [NGC-1:0] gclk;
    logic           pt_clk, pt_rst, pt_set;
    logic           cfg_registered, cfg_invert, cfg_async, cfg_clk_fall;
    logic [2:0]     cfg_kind;
    logic [1:0]     cfg_clk_sel;
    logic           preload_en, preload_val;
    logic           q_obs, pin_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    macrocell_core #(.NUM_PT(NPT), .NUM_GCLK(NGC)) uut (
        .clk(clk), .rst_n(rst_n), .pt_sum(pt_sum), .pt_aux(pt_aux),
        .xor_term(xor_term), .gclk(gclk), .pt_clk(pt_clk), .pt_rst(pt_rst),
        .pt_set(pt_set), .cfg_registered(cfg_registered), .cfg_invert(cfg_invert),
        .cfg_kind(cfg_kind), .cfg_async(cfg_async), .cfg_clk_sel(cfg_clk_sel),
        .cfg_clk_fall(cfg_clk_fall), .preload_en(preload_en),
        .preload_val(preload_val), .q_obs(q_obs), .pin_out(pin_out)
    );

    // Vector fields: kind[5:3], main input [2], second input [1], expected bit [0]
    localparam logic [5:0] VEC [15] = '{
        {3'd0, 1'b1, 1'b0, 1'b1},
        {3'd0, 1'b0, 1'b0, 1'b0},
        {3'd1, 1'b1, 1'b0, 1'b1},
        {3'd1, 1'b0, 1'b0, 1'b1},
        {3'd1, 1'b1, 1'b0, 1'b0},
        {3'd2, 1'b1, 1'b0, 1'b1},
        {3'd2, 1'b0, 1'b0, 1'b1},
        {3'd2, 1'b1, 1'b1, 1'b0},
        {3'd2, 1'b1, 1'b1, 1'b1},
        {3'd2, 1'b0, 1'b1, 1'b0},
        {3'd3, 1'b1, 1'b0, 1'b1},
        {3'd3, 1'b1, 1'b1, 1'b1},
        {3'd3, 1'b0, 1'b1, 1'b0},
        {3'd3, 1'b1, 1'b1, 1'b0},
        {3'd3, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string kind_tag(input logic [2:0] k);
        case (k)
            3'd0:    return "R3 D";
            3'd1:    return "R4 T";
            3'd2:    return "R5 JK";
            default: return "R6 SR";
        endcase
    endfunction

    task automatic set_a(input logic a);
        pt_sum = '0;
        pt_sum[0] = a;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; pt_sum = '0; pt_aux = '0; xor_term = 1'b0; gclk = '0;
        pt_clk = 1'b0; pt_rst = 1'b0; pt_set = 1'b0;
        cfg_registered = 1'b1; cfg_invert = 1'b0; cfg_kind = 3'd0;
        cfg_async = 1'b0; cfg_clk_sel = 2'd0; cfg_clk_fall = 1'b0;
        preload_en = 1'b0; preload_val = 1'b0;
        @(negedge clk);
        tick();
        tick();
        check("R10 reset q", q_obs, 1'b0);
        check("R10 reset pin", pin_out, 1'b0);
        rst_n = 1'b1;
        tick();

        // Table walk: one rising event on gclk[0] per vector
        for (int i = 0; i < 15; i++) begin
            cfg_kind = VEC[i][5:3];
            set_a(VEC[i][2]);
            pt_aux = '0;
            pt_aux[11] = VEC[i][1];
            gclk[0] = 1'b1;
            tick();
            check(kind_tag(VEC[i][5:3]), q_obs, VEC[i][0]);
            check("R2 pin true polarity", pin_out, VEC[i][0]);
            gclk[0] = 1'b0;
            tick();
        end
        pt_aux = '0;

        // R8: falling edge of gclk[2]
        cfg_kind = 3'd0; set_a(1'b0);
        cfg_clk_sel = 2'd2; cfg_clk_fall = 1'b1;
        tick();
        set_a(1'b1);
        gclk[2] = 1'b1; tick();
        check("R8 rising ignored when falling chosen", q_obs, 1'b0);
        gclk[0] = 1'b1; tick();
        gclk[0] = 1'b0; tick();
        check("R8 unselected line ignored", q_obs, 1'b0);
        gclk[2] = 1'b0; tick();
        check("R8 falling edge captures", q_obs, 1'b1);
        cfg_clk_sel = 2'd0; cfg_clk_fall = 1'b0;
        tick();

        // R7: latch
        cfg_kind = 3'd4; set_a(1'b0);
        gclk[0] = 1'b1; tick();
        check("R7 latch open follows 0", q_obs, 1'b0);
        set_a(1'b1); tick();
        check("R7 latch open follows 1", q_obs, 1'b1);
        gclk[0] = 1'b0; tick();
        set_a(1'b0); tick();
        check("R7 latch closed holds", q_obs, 1'b1);

        // R9: asynchronous mode
        cfg_kind = 3'd0; cfg_async = 1'b1;
        tick();
        gclk[0] = 1'b1; tick();
        gclk[0] = 1'b0; tick();
        check("R9 global clock ignored in async", q_obs, 1'b1);
        pt_clk = 1'b1; tick();
        check("R9 pt_clk rising captures", q_obs, 1'b0);
        pt_clk = 1'b0; tick();
        pt_set = 1'b1; tick();
        check("R9 preset sets", q_obs, 1'b1);
        pt_rst = 1'b1; tick();
        check("R9 reset beats preset", q_obs, 1'b0);
        pt_set = 1'b0; set_a(1'b1); pt_clk = 1'b1; tick();
        check("R9 reset beats clocked data", q_obs, 1'b0);
        pt_rst = 1'b0; pt_clk = 1'b0; set_a(1'b0); tick();
        cfg_async = 1'b0; tick();
        pt_set = 1'b1; tick();
        check("R9 preset ignored in sync", q_obs, 1'b0);
        pt_set = 1'b0;
        preload_en = 1'b1; preload_val = 1'b1; tick();
        preload_en = 1'b0;
        pt_rst = 1'b1; tick();
        check("R9 reset ignored in sync", q_obs, 1'b1);
        pt_rst = 1'b0;

        // R11: preload priority
        cfg_async = 1'b1; pt_rst = 1'b1;
        preload_en = 1'b1; preload_val = 1'b0; tick();
        preload_val = 1'b1; tick();
        check("R11 preload beats pt reset", q_obs, 1'b1);
        preload_en = 1'b0; tick();
        check("R9 pt reset after preload", q_obs, 1'b0);
        pt_rst = 1'b0; cfg_async = 1'b0; tick();
        set_a(1'b1); preload_en = 1'b1; preload_val = 1'b0; gclk[0] = 1'b1; tick();
        check("R11 preload beats clock event", q_obs, 1'b0);
        preload_en = 1'b0; gclk[0] = 1'b0; tick();
        gclk[0] = 1'b1; tick();
        check("R3 D capture after preload", q_obs, 1'b1);
        gclk[0] = 1'b0; tick();
        cfg_invert = 1'b1; #1;
        check("R2 inverted pin", pin_out, 1'b0);

        // R1 / R12: combinational path
        cfg_registered = 1'b0; cfg_invert = 1'b0;
        pt_sum = '0; pt_sum[7] = 1'b1; xor_term = 1'b0; #1;
        check("R12 single term", pin_out, 1'b1);
        xor_term = 1'b1; #1;
        check("R12 xor inverts", pin_out, 1'b0);
        pt_sum = '0; #1;
        check("R1 no terms with xor", pin_out, 1'b1);
        cfg_invert = 1'b1; #1;
        check("R1 comb with inversion", pin_out, 1'b0);
        pt_sum[NPT-1] = 1'b1; #1;
        check("R12 top term", pin_out, 1'b1);
        xor_term = 1'b0;
        @(negedge clk);

        // R10: reset after activity, inverted polarity
        cfg_registered = 1'b1; cfg_invert = 1'b1;
        rst_n = 1'b0; tick();
        check("R10 reset clears", q_obs, 1'b0);
        check("R10 pin shows polarity", pin_out, 1'b1);
        rst_n = 1'b1; tick();

        done = 1'b1;
        finish_run();
    end

endmodule